// File: doc/BRIEF.md
# 32-Pin GPIO Port with Set/Clear Aliases

This block is a general-purpose I/O port of up to 32 pins. Software reaches it through a simple register interface with one-cycle read and write strobes and a byte address. Each pin is controlled by three things: a bit in the output latch, a direction bit, and a small per-pin configuration word. That word holds the direction, an input-buffer disconnect and a pull selection. Both the latch and the direction register have write-one-to-set and write-one-to-clear alias addresses, so one pin can be changed without a read-modify-write.

On the pin side, the outside world is modelled per pin as a driven/undriven flag plus a level. The port returns an output value and an output enable for each pin. A registered input sample combines four things for each pin: the external drive, the pull, the buffer disconnect and the port's own driven value. When the port and the outside drive one pin to opposite levels, a sticky short-circuit flag is raised.

The direction bit has a single storage location per pin. It can be reached through the packed direction register, through its aliases, or through bit 0 of that pin's configuration word.

Top module: `gpio_port`

## Requirements
- R1: After reset, the latch, input, direction and status addresses and all four alias addresses read 0. Every per-pin configuration word reads 0x2 (input, buffer disconnected, no pull).
- R2: Address map and latch aliases:
  - The latch is at 0x00, its set alias at 0x04 and its clear alias at 0x08.
  - A write to 0x00 replaces the latch. A write to 0x04 ORs the data into the latch. A write to 0x08 clears the latch bits where the data is 1.
  - Reads of 0x04 and 0x08 return the latch.
- R3: Direction and its aliases:
  - The direction register is at 0x10, its set alias at 0x14 and its clear alias at 0x18. They use the same replace, set and clear rules as the latch.
  - Reads of 0x14 and 0x18 return the direction register.
- R4: The configuration word of pin n sits at 0x80 + 4·n. Its bit 0 and bit n of the direction register are the same storage: a change made through either one reads back through the other.
- R5: Configuration word layout:
  - Bit 0 is the direction (1 = output).
  - Bit 1 is the input disconnect (1 = disconnected).
  - Bits 3:2 are the pull: 00 none, 01 pull-down, 11 pull-up, 10 treated as none.
  - Written values read back in bits 3:0, and bits 31:4 read 0.
- R6: Output pins:
  - pin_oe[n] equals the direction bit of pin n.
  - pin_out[n] equals latch bit n when the pin is an output, and 0 otherwise.
- R7: For a connected input pin with no pull that is externally driven, input bit n (address 0x0C) takes the external level one cycle after the level is applied.
- R8: For a connected input pin with no pull that is not externally driven, input bit n keeps its previous value.
- R9: For a connected input pin, pull-up forces input bit n to 1 and pull-down forces it to 0, whatever the external drive is.
- R10: For a connected output pin, input bit n shows the pin's latch bit.
- R11: For a pin whose input buffer is disconnected, input bit n keeps its previous value under any stimulus.
- R12: Short-circuit flag:
  - The flag is set when a pin is an output and is externally driven to the level opposite its latch bit.
  - It reads as status bit 0 (address 0x1C) and on short_err, and stays set until 1 is written to status bit 0.
  - A conflict in the same cycle wins over that clear, and writing 0 has no effect.
- R13: Read path and ignored accesses:
  - Writes to the input address are ignored.
  - Unmapped addresses read 0. Address bits 1:0 are ignored.
  - rd_data is registered: it updates on the clock edge where rd_en is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| addr | input | 8 | Byte address of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| ext_drive | input | NPINS | Per pin: outside source is driving |
| ext_level | input | NPINS | Per pin: level driven by the outside source |
| pin_out | output | NPINS | Per-pin output value |
| pin_oe | output | NPINS | Per-pin output enable |
| short_err | output | 1 | Sticky short-circuit flag |

## Verification
The hardest states to reach are the holding cases: an undriven input, or a disconnected buffer, must keep whatever value the previous stimulus left there. The bench therefore sweeps every pin through all sixteen configuration words and both latch values. For each of these it applies the external patterns in an order where a released drive follows both a driven 1 and a driven 0. A model updated on every clock edge predicts each held value. The sweep also reaches the set-over-clear race on the short flag, because it writes the status clear while a conflict is still being applied.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int MAX_PINS = 32;

    localparam logic [ADDR_W-1:0] OFF_OUT      = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_OUTSET   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_OUTCLR   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_IN       = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_DIR      = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DIRSET   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_DIRCLR   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CFG_BASE = 8'h80;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_DOWN = 2'b01,
        PULL_RSVD = 2'b10,
        PULL_UP   = 2'b11
    } pull_e;

    // bit order matches the software view: [3:2] pull, [1] disconnect, [0] direction
    typedef struct packed {
        pull_e pull;
        logic  disc;
        logic  dir;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{pull: PULL_NONE, disc: 1'b1, dir: 1'b0};

    typedef enum logic [3:0] {
        ACC_NONE, ACC_OUT, ACC_OUTSET, ACC_OUTCLR, ACC_IN,
        ACC_DIR, ACC_DIRSET, ACC_DIRCLR, ACC_STATUS, ACC_CFG
    } acc_e;

    typedef struct packed {
        acc_e       kind;
        logic [4:0] pin;
    } dec_t;

    typedef struct packed {
        logic upd;
        logic val;
    } in_res_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int npins);
        dec_t d;
        d.kind = ACC_NONE;
        d.pin  = a[6:2];
        if (a[7]) begin
            if (int'(a[6:2]) < npins) d.kind = ACC_CFG;
        end else begin
            case ({a[7:2], 2'b00})
                OFF_OUT:    d.kind = ACC_OUT;
                OFF_OUTSET: d.kind = ACC_OUTSET;
                OFF_OUTCLR: d.kind = ACC_OUTCLR;
                OFF_IN:     d.kind = ACC_IN;
                OFF_DIR:    d.kind = ACC_DIR;
                OFF_DIRSET: d.kind = ACC_DIRSET;
                OFF_DIRCLR: d.kind = ACC_DIRCLR;
                OFF_STATUS: d.kind = ACC_STATUS;
                default:    d.kind = ACC_NONE;
            endcase
        end
        return d;
    endfunction

    // Decide what the input sample of one pin becomes this cycle.
    function automatic in_res_t resolve_pin(input pin_cfg_t c, input logic out_bit,
                                            input logic drv, input logic lvl);
        in_res_t r;
        r.upd = 1'b0;
        r.val = 1'b0;
        if (!c.disc) begin
            if (c.dir) begin
                r.upd = 1'b1;
                r.val = out_bit;
            end else if (c.pull == PULL_UP) begin
                r.upd = 1'b1;
                r.val = 1'b1;
            end else if (c.pull == PULL_DOWN) begin
                r.upd = 1'b1;
                r.val = 1'b0;
            end else if (drv) begin
                r.upd = 1'b1;
                r.val = lvl;
            end
        end
        return r;
    endfunction

    function automatic logic pin_conflict(input pin_cfg_t c, input logic out_bit,
                                          input logic drv, input logic lvl);
        return c.dir & drv & (lvl ^ out_bit);
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  dec_t                        wdec,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NPINS-1:0]            out_q,
    output pin_cfg_t [NPINS-1:0]        cfg_q
);
    logic [NPINS-1:0] wmask;
    assign wmask = wdata[NPINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (wr_en) begin
            case (wdec.kind)
                ACC_OUT:    out_q <= wmask;
                ACC_OUTSET: out_q <= out_q | wmask;
                ACC_OUTCLR: out_q <= out_q & ~wmask;
                default:    out_q <= out_q;
            endcase
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_cfg
        pin_cfg_t cfg_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_r <= CFG_RESET;
            end else if (wr_en) begin
                case (wdec.kind)
                    ACC_DIR:    cfg_r.dir <= wdata[i];
                    ACC_DIRSET: if (wdata[i]) cfg_r.dir <= 1'b1;
                    ACC_DIRCLR: if (wdata[i]) cfg_r.dir <= 1'b0;
                    ACC_CFG:    if (wdec.pin == 5'(i)) cfg_r <= pin_cfg_t'(wdata[3:0]);
                    default:    cfg_r <= cfg_r;
                endcase
            end
        end
        assign cfg_q[i] = cfg_r;
    end
endmodule

// File: rtl/gpio_port_sense.sv
module gpio_port_sense
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_cfg_t [NPINS-1:0] cfg,
    input  logic [NPINS-1:0]     out_q,
    input  logic [NPINS-1:0]     ext_drive,
    input  logic [NPINS-1:0]     ext_level,
    input  logic                 sts_clr,
    output logic [NPINS-1:0]     in_q,
    output logic                 short_q
);
    logic [NPINS-1:0] conf;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        in_res_t res;
        logic    bit_q;
        assign res = resolve_pin(cfg[i], out_q[i], ext_drive[i], ext_level[i]);
        always_ff @(posedge clk) begin
            if (rst)          bit_q <= 1'b0;
            else if (res.upd) bit_q <= res.val;
        end
        assign in_q[i] = bit_q;
        assign conf[i] = pin_conflict(cfg[i], out_q[i], ext_drive[i], ext_level[i]);
    end

    // a new conflict outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)          short_q <= 1'b0;
        else if (|conf)   short_q <= 1'b1;
        else if (sts_clr) short_q <= 1'b0;
    end
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  dec_t                 rdec,
    input  logic [NPINS-1:0]     out_q,
    input  logic [NPINS-1:0]     dir_vec,
    input  logic [NPINS-1:0]     in_q,
    input  pin_cfg_t [NPINS-1:0] cfg,
    input  logic                 short_q,
    output logic [DATA_W-1:0]    rd_data
);
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        case (rdec.kind)
            ACC_OUT, ACC_OUTSET, ACC_OUTCLR: rd_next = DATA_W'(out_q);
            ACC_DIR, ACC_DIRSET, ACC_DIRCLR: rd_next = DATA_W'(dir_vec);
            ACC_IN:     rd_next = DATA_W'(in_q);
            ACC_STATUS: rd_next = DATA_W'(short_q);
            ACC_CFG:    rd_next = DATA_W'(cfg[rdec.pin]);
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic [NPINS-1:0]  ext_drive,
    input  logic [NPINS-1:0]  ext_level,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              short_err
);
    dec_t                 dec;
    logic [NPINS-1:0]     out_q;
    pin_cfg_t [NPINS-1:0] cfg_q;
    logic [NPINS-1:0]     dir_vec;
    logic [NPINS-1:0]     in_q;
    logic                 short_q;
    logic                 sts_clr;

    assign dec     = decode_addr(addr, NPINS);
    assign sts_clr = wr_en && (dec.kind == ACC_STATUS) && wr_data[0];

    for (genvar i = 0; i < NPINS; i++) begin : g_dir
        assign dir_vec[i] = cfg_q[i].dir;
    end

    gpio_port_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdec(dec), .wdata(wr_data),
        .out_q(out_q), .cfg_q(cfg_q)
    );

    gpio_port_sense #(.NPINS(NPINS)) u_sense (
        .clk(clk), .rst(rst), .cfg(cfg_q), .out_q(out_q),
        .ext_drive(ext_drive), .ext_level(ext_level), .sts_clr(sts_clr),
        .in_q(in_q), .short_q(short_q)
    );

    gpio_port_rdmux #(.NPINS(NPINS)) u_rdmux (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rdec(dec), .out_q(out_q),
        .dir_vec(dir_vec), .in_q(in_q), .cfg(cfg_q), .short_q(short_q),
        .rd_data(rd_data)
    );

    assign pin_oe    = dir_vec;
    assign pin_out   = out_q & dir_vec;
    assign short_err = short_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [31:0]      wr_data,
    input logic [31:0]      rd_data,
    input logic [NPINS-1:0] ext_drive,
    input logic [NPINS-1:0] ext_level,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             short_err
);
    logic wr_outset, wr_outclr, wr_dir, wr_clr1;
    assign wr_outset = wr_en && ({addr[7:2], 2'b00} == OFF_OUTSET);
    assign wr_outclr = wr_en && ({addr[7:2], 2'b00} == OFF_OUTCLR);
    assign wr_dir    = wr_en && ({addr[7:2], 2'b00} == OFF_DIR);
    assign wr_clr1   = wr_en && ({addr[7:2], 2'b00} == OFF_STATUS) && wr_data[0];

    AST_OUTSET_ORS: assert property (@(posedge clk) disable iff (rst)
        wr_outset && (pin_oe == '1) |=> pin_out == ($past(pin_out) | $past(wr_data[NPINS-1:0]))); // R2
    AST_OUTCLR_MASKS: assert property (@(posedge clk) disable iff (rst)
        wr_outclr |=> (pin_out & $past(wr_data[NPINS-1:0])) == '0); // R2
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> pin_oe == $past(wr_data[NPINS-1:0])); // R3
    AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0); // R6
    AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (rst)
        short_err && !wr_clr1 |=> short_err); // R12
    AST_SHORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(short_err) |-> $past(|(pin_oe & ext_drive & (ext_level ^ pin_out)))); // R12
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R13
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) i_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ext_drive(ext_drive),
    .ext_level(ext_level), .pin_out(pin_out), .pin_oe(pin_oe),
    .short_err(short_err)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [N-1:0]  ext_drive = '0;
    logic [N-1:0]  ext_level = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          short_err;

    gpio_port #(.NPINS(N)) i_gpio_port (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .ext_drive(ext_drive),
        .ext_level(ext_level), .pin_out(pin_out), .pin_oe(pin_oe),
        .short_err(short_err)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    // reference model
    logic [31:0] m_out  = '0;
    logic [31:0] m_dir  = '0;
    logic [31:0] m_disc = '1;
    logic [31:0] m_pu   = '0;
    logic [31:0] m_pd   = '0;
    logic [31:0] m_pr   = '0;
    logic [31:0] m_in   = '0;
    bit          m_short = 1'b0;
    logic [31:0] exp_rd = '0;
    string       rd_req = "R13";

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int p;
        logic [7:0] w = {a[7:2], 2'b00};
        if (w >= 8'h80) begin
            p = int'(w - 8'h80) / 4;
            return {28'b0, m_pu[p], m_pd[p] | m_pu[p] ? 1'b1 : 1'b0, m_disc[p], m_dir[p]} & 32'h0
                 | {28'b0, (m_pu[p] | m_pr[p]), (m_pu[p] | m_pd[p]), m_disc[p], m_dir[p]};
        end
        case (w)
            8'h00, 8'h04, 8'h08: return m_out;
            8'h0C:               return m_in;
            8'h10, 8'h14, 8'h18: return m_dir;
            8'h1C:               return {31'b0, m_short};
            default:             return 32'h0;
        endcase
    endfunction

    task automatic model_edge(input bit we, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] nin = m_in;
        bit conf = 1'b0;
        logic [7:0] w = {a[7:2], 2'b00};
        int p;
        for (int i = 0; i < N; i++) begin
            if (!m_disc[i]) begin
                if (m_dir[i])      nin[i] = m_out[i];
                else if (m_pu[i])  nin[i] = 1'b1;
                else if (m_pd[i])  nin[i] = 1'b0;
                else if (ext_drive[i]) nin[i] = ext_level[i];
            end
            if (m_dir[i] && ext_drive[i] && (ext_level[i] != m_out[i])) conf = 1'b1;
        end
        if (conf) m_short = 1'b1;
        else if (we && w == 8'h1C && d[0]) m_short = 1'b0;
        if (we) begin
            if (w >= 8'h80) begin
                p = int'(w - 8'h80) / 4;
                m_dir[p]  = d[0];
                m_disc[p] = d[1];
                m_pd[p]   = (d[3:2] == 2'b01);
                m_pu[p]   = (d[3:2] == 2'b11);
                m_pr[p]   = (d[3:2] == 2'b10);
            end else begin
                case (w)
                    8'h00: m_out = d;
                    8'h04: m_out = m_out | d;
                    8'h08: m_out = m_out & ~d;
                    8'h10: m_dir = d;
                    8'h14: m_dir = m_dir | d;
                    8'h18: m_dir = m_dir & ~d;
                    default: ;
                endcase
            end
        end
        m_in = nin;
    endtask

    // one clock: drive strobes, advance the model, check the ports afterwards
    task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input bit re, input string req);
        wr_en = we; rd_en = re; addr = a; wr_data = d;
        if (re) begin
            exp_rd = model_read(a);
            rd_req = req;
        end
        model_edge(we, a, d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rd_data === exp_rd, rd_req, rd_data, exp_rd);
        chk(pin_oe === m_dir, "R6", pin_oe, m_dir);
        chk(pin_out === (m_out & m_dir), "R6", pin_out, m_out & m_dir);
        chk(short_err === m_short, "R12", {31'b0, short_err}, {31'b0, m_short});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, rd_req);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        cyc(1'b0, a, '0, 1'b1, req);
    endtask

    function automatic logic [7:0] cfga(input int p);
        return 8'(8'h80 + 4 * p);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        foreach (m_in[k]) ;
        rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h0C, "R1");
        rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h18, "R1"); rd(8'h1C, "R1");
        for (int p = 0; p < N; p++) rd(cfga(p), "R1");

        // R2: latch and its aliases
        wr(8'h00, 32'h1234_5678); rd(8'h00, "R2");
        wr(8'h04, 32'h8000_0001); rd(8'h04, "R2"); rd(8'h08, "R2"); rd(8'h00, "R2");
        wr(8'h08, 32'h0000_0078); rd(8'h00, "R2");
        wr(8'h00, 32'h0);         rd(8'h08, "R2");

        // R3: direction and its aliases
        wr(8'h10, 32'hF0F0_0F0F); rd(8'h10, "R3");
        wr(8'h14, 32'h8000_0001); rd(8'h14, "R3");
        wr(8'h18, 32'h0F00_0003); rd(8'h18, "R3"); rd(8'h10, "R3");
        wr(8'h10, 32'h0);

        // R4: shared direction bit
        wr(8'h14, 32'h8000_0001); rd(cfga(0), "R4"); rd(cfga(31), "R4");
        wr(8'h18, 32'h8000_0001); rd(cfga(0), "R4"); rd(cfga(31), "R4");
        wr(cfga(5), 32'h1); rd(8'h10, "R4");
        wr(cfga(5), 32'h2); rd(8'h10, "R4");

        // R5: layout and readback of every pin word
        for (int p = 0; p < N; p++) begin
            wr(cfga(p), 32'hFFFF_FFF0 | 32'(p % 16));
            rd(cfga(p), "R5");
        end
        for (int p = 0; p < N; p++) wr(cfga(p), 32'h2);

        // R13: ignored write, unmapped reads, held read data
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, "R13");
        rd(8'h20, "R13"); rd(8'h7C, "R13"); rd(8'h03, "R13");
        cyc(1'b0, 8'h00, 32'h0, 1'b0, "R13");

        // R12: set, clear by 0 ignored, clear by 1
        wr(cfga(3), 32'h1); wr(8'h08, 32'hFFFF_FFFF);
        ext_drive = 32'h8; ext_level = 32'h8;
        cyc(1'b0, 8'h00, 32'h0, 1'b0, "R12");
        ext_drive = '0; ext_level = '0;
        rd(8'h1C, "R12");
        wr(8'h1C, 32'h0); rd(8'h1C, "R12");
        wr(8'h1C, 32'h1); rd(8'h1C, "R12");
        wr(cfga(3), 32'h2);

        // full sweep: every pin, config word, latch bit and external pattern
        for (int p = 0; p < N; p++) begin
            for (int cv = 0; cv < 16; cv++) begin
                for (int ob = 0; ob < 2; ob++) begin
                    wr(cfga(p), 32'(cv));
                    wr(ob ? 8'h04 : 8'h08, 32'h1 << p);
                    for (int k = 0; k < 4; k++) begin
                        int ev;
                        string tag;
                        ev = (k == 0) ? 3 : (k == 1) ? 0 : (k == 2) ? 2 : 1;
                        ext_drive = ev[1] ? (32'h1 << p) : 32'h0;
                        ext_level = (ev[0] ? (32'h1 << p) : 32'h0) | (32'hA5A5_A5A5 & ~(32'h1 << p));
                        if (cv[1])                     tag = "R11";
                        else if (cv[0])                tag = "R10";
                        else if (cv[3:2] == 2'b11 || cv[3:2] == 2'b01) tag = "R9";
                        else if (ev[1])                tag = "R7";
                        else                           tag = "R8";
                        cyc(1'b0, 8'h00, 32'h0, 1'b0, tag);
                        rd(8'h0C, tag);
                        rd(8'h1C, "R12");
                        wr(8'h1C, 32'h1);
                    end
                end
            end
            ext_drive = '0;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule